// File: doc/BRIEF.md
# Eight-Bit Register-File Processor Core

This block is a small multi-cycle processor. It fetches 16-bit instruction words from an external program store, holds sixteen 8-bit working registers, and exchanges data with an external byte-wide RAM. Its instructions cover copies between registers, immediate loads (direct and indirect), RAM loads and stores, increment and decrement, six two-source ALU operations with a separate destination, four branches that are taken when a chosen flag is clear, a no-operation and a halt.

Program memory is read combinationally: the core presents the program counter on `pm_addr` and samples `pm_data` at the end of the fetch phase. The RAM port is a plain synchronous port. A write strobe lasts one cycle. A read strobe returns data on `ram_rdata` one cycle later, and the core spends one extra phase waiting for it. No port here carries a stream, so none of them has a valid/ready handshake and there is no back-pressure: the program store and the RAM must respond within the stated fixed latencies. Once the halt instruction executes, the core sits idle with `halted` high until reset.

Top module: `reg8_core`

## Requirements
- R1: A synchronous active-high `rst` clears the program counter, the flags, all registers and `halted`, and the next instruction fetch comes from address 0.
- R2: Each instruction takes three cycles (fetch, decode, execute). A RAM load takes four. `pm_addr` always shows the program counter, which changes only at the end of the execute phase.
- R3: Opcode 0 (move) copies the register named in field A (bits 11:8) into the register named in field B (bits 7:4). No flag changes.
- R4: Opcode 1 writes the 8-bit immediate (bits 7:0) into register A. Opcode 2 writes the immediate into the register whose index is the low four bits of register A's contents. Neither changes a flag.
- R5: Opcode 3 pulses `ram_re` for one cycle with `ram_addr` equal to the immediate, waits one cycle, then writes `ram_rdata` into register A.
- R6: Opcode 4 pulses `ram_we` for one cycle with `ram_addr` equal to the immediate and `ram_wdata` equal to register A. `ram_we` and `ram_re` are never high together.
- R7: Opcodes 5 and 6 add or subtract one from register A modulo 256. They update zero, negative and signed overflow (overflow is set on 0x7F+1 and on 0x80-1).
- R8: Opcodes 9 to 12 (add, subtract, AND, OR) combine registers A and B and write register C (bits 3:0). They read both sources before the write, so C may equal a source. They set zero and negative from the result. Add and subtract also set signed overflow.
- R9: Opcodes 13 and 14 shift register A left or right by the value in register B. Amounts of 8 or more give 0. Zero and negative follow the result. A right shift sets the underflow flag exactly when a 1 bit is discarded; a left shift clears it.
- R10: Opcode 7 branches to the absolute address in bits 7:0 when the flag chosen by bits 11:10 is clear (0 zero, 1 negative, 2 overflow, 3 underflow). Otherwise it goes to the next address.
- R11: Opcode 8 halts. `halted` stays high, the program counter stays frozen and no RAM strobe is issued until reset.
- R12: Opcode 15 does nothing except advance the program counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| pm_addr | output | 8 | Program memory address (program counter) |
| pm_data | input | 16 | Instruction word at `pm_addr` |
| ram_addr | output | 8 | RAM address for load and store |
| ram_wdata | output | 8 | RAM write data |
| ram_we | output | 1 | RAM write strobe, one cycle |
| ram_re | output | 1 | RAM read strobe, data expected next cycle |
| ram_rdata | input | 8 | RAM read data |
| halted | output | 1 | High once the halt instruction has executed |

## Verification
In the execute phase two things land on the same clock edge: the ALU writes its result into the register bank, and the flags are updated. That same edge also matters when the destination register is one of the sources. The program provokes this with an add whose three fields name one register, and with a store placed right after a load, so that a late write-back or a wrong operand latch would show up. A behavioural model in the bench executes each instruction and is compared every clock against `pm_addr`, the RAM strobes, address and data, and `halted`. Branches that test flags written by the instruction just before them check that flag and register updates really completed in the same edge.

// File: rtl/mcore_pkg.sv
package mcore_pkg;

  typedef enum logic [3:0] {
    OP_MOV  = 4'd0,
    OP_LDI  = 4'd1,
    OP_ILDI = 4'd2,
    OP_LOAD = 4'd3,
    OP_ST   = 4'd4,
    OP_INC  = 4'd5,
    OP_DEC  = 4'd6,
    OP_BR   = 4'd7,
    OP_END  = 4'd8,
    OP_ADD  = 4'd9,
    OP_SUB  = 4'd10,
    OP_AND  = 4'd11,
    OP_OR   = 4'd12,
    OP_SHL  = 4'd13,
    OP_SHR  = 4'd14,
    OP_NOP  = 4'd15
  } opcode_t;

  typedef enum logic [2:0] {
    PH_FETCH,
    PH_DECODE,
    PH_EXEC,
    PH_MEMWAIT,
    PH_HALT
  } phase_t;

  typedef enum logic [1:0] {
    CC_ZERO  = 2'd0,
    CC_NEG   = 2'd1,
    CC_OVF   = 2'd2,
    CC_UNDER = 2'd3
  } cond_t;

  typedef struct packed {
    logic z;
    logic n;
    logic v;
    logic u;
  } flags_t;

endpackage

// File: rtl/mcore_regfile.sv
module mcore_regfile #(
  parameter int DATA_W = 8,
  parameter int RA_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [RA_W-1:0]   widx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [RA_W-1:0]   ra,
  input  logic [RA_W-1:0]   rb,
  output logic [DATA_W-1:0] rd_a,
  output logic [DATA_W-1:0] rd_b
);
  localparam int NREG = 1 << RA_W;

  logic [NREG-1:0][DATA_W-1:0] bank;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk) begin
      if (rst)                           q <= '0;
      else if (we && widx == RA_W'(i))   q <= wdata;
    end
    assign bank[i] = q;
  end

  assign rd_a = bank[ra];
  assign rd_b = bank[rb];

  // R8: a write reaches the addressed entry on the following cycle
  p_write_lands_r8: assert property (@(posedge clk) disable iff (rst)
    we |=> bank[$past(widx)] == $past(wdata));

endmodule

// File: rtl/mcore_alu.sv
module mcore_alu import mcore_pkg::*; #(
  parameter int DATA_W = 8
) (
  input  opcode_t           op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  flags_t            f_in,
  output logic [DATA_W-1:0] res,
  output flags_t            f_out,
  output logic              f_we
);
  localparam logic [DATA_W-1:0] MAX_POS = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] MIN_NEG = {1'b1, {(DATA_W-1){1'b0}}};
  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] sum, diff, lost_mask;

  assign sum       = a + b;
  assign diff      = a - b;
  assign lost_mask = ~({DATA_W{1'b1}} << b);

  always_comb begin
    res   = '0;
    f_out = f_in;
    f_we  = 1'b0;
    unique case (op)
      OP_INC: begin
        res = a + 1'b1; f_we = 1'b1; f_out.v = (a == MAX_POS);
      end
      OP_DEC: begin
        res = a - 1'b1; f_we = 1'b1; f_out.v = (a == MIN_NEG);
      end
      OP_ADD: begin
        res = sum; f_we = 1'b1;
        f_out.v = (a[MSB] == b[MSB]) && (sum[MSB] != a[MSB]);
      end
      OP_SUB: begin
        res = diff; f_we = 1'b1;
        f_out.v = (a[MSB] != b[MSB]) && (diff[MSB] != a[MSB]);
      end
      OP_AND: begin res = a & b; f_we = 1'b1; end
      OP_OR:  begin res = a | b; f_we = 1'b1; end
      OP_SHL: begin
        res = a << b; f_we = 1'b1; f_out.u = 1'b0;
      end
      OP_SHR: begin
        res = a >> b; f_we = 1'b1; f_out.u = |(a & lost_mask);
      end
      default: ;
    endcase
    if (f_we) begin
      f_out.z = (res == '0);
      f_out.n = res[MSB];
    end
  end

endmodule

// File: rtl/mcore_seq.sv
module mcore_seq import mcore_pkg::*; #(
  parameter int IW   = 16,
  parameter int PC_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [IW-1:0]   pm_data,
  input  opcode_t         op,
  input  cond_t           cond,
  input  logic [PC_W-1:0] target,
  input  flags_t          f_next,
  input  logic            f_we,
  output phase_t          phase,
  output logic [IW-1:0]   ir,
  output logic [PC_W-1:0] pc,
  output flags_t          flags
);
  logic flag_sel, taken;

  always_comb begin
    unique case (cond)
      CC_ZERO:  flag_sel = flags.z;
      CC_NEG:   flag_sel = flags.n;
      CC_OVF:   flag_sel = flags.v;
      default:  flag_sel = flags.u;
    endcase
  end

  assign taken = (op == OP_BR) && !flag_sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_FETCH;
      pc    <= '0;
      ir    <= '0;
      flags <= '0;
    end else begin
      unique case (phase)
        PH_FETCH: begin
          ir    <= pm_data;
          phase <= PH_DECODE;
        end
        PH_DECODE: phase <= PH_EXEC;
        PH_EXEC: begin
          if (f_we) flags <= f_next;
          if (op == OP_END) begin
            phase <= PH_HALT;
          end else begin
            pc    <= taken ? target : pc + 1'b1;
            phase <= (op == OP_LOAD) ? PH_MEMWAIT : PH_FETCH;
          end
        end
        PH_MEMWAIT: phase <= PH_FETCH;
        default:    phase <= PH_HALT;
      endcase
    end
  end

  // R11: halt is permanent until reset
  p_halt_sticky_r11: assert property (@(posedge clk) disable iff (rst)
    phase == PH_HALT |=> phase == PH_HALT);
  // R11: program counter frozen while halted
  p_pc_frozen_r11: assert property (@(posedge clk) disable iff (rst)
    phase == PH_HALT |=> $stable(pc));
  // R5: a load always spends one wait phase
  p_load_wait_r5: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_EXEC && op == OP_LOAD) |=> phase == PH_MEMWAIT);
  // R2: non-load, non-halt instructions return to fetch
  p_three_cycle_r2: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_EXEC && op != OP_LOAD && op != OP_END) |=> phase == PH_FETCH);
  // R2: program counter only moves at the end of execute
  p_pc_moves_in_exec_r2: assert property (@(posedge clk) disable iff (rst)
    (phase != PH_EXEC) |=> $stable(pc));

endmodule

// File: rtl/reg8_core.sv
module reg8_core import mcore_pkg::*; #(
  parameter int DATA_W = 8,
  parameter int RA_W   = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  output logic [2*RA_W-1:0]       pm_addr,
  input  logic [4+3*RA_W-1:0]     pm_data,
  output logic [2*RA_W-1:0]       ram_addr,
  output logic [DATA_W-1:0]       ram_wdata,
  output logic                    ram_we,
  output logic                    ram_re,
  input  logic [DATA_W-1:0]       ram_rdata,
  output logic                    halted
);
  localparam int IMM_W = 2 * RA_W;
  localparam int IW    = 4 + 3 * RA_W;
  localparam int PC_W  = IMM_W;

  phase_t            phase;
  logic [IW-1:0]     ir;
  logic [PC_W-1:0]   pc;
  flags_t            flags, alu_flags;
  logic              alu_fwe;
  opcode_t           op;
  cond_t             cond;
  logic [RA_W-1:0]   fa, fb, fc;
  logic [IMM_W-1:0]  imm;
  logic [DATA_W-1:0] rd_a, rd_b, opa, opb, alu_res;
  logic              wr_en;
  logic [RA_W-1:0]   wr_idx;
  logic [DATA_W-1:0] wr_data;

  assign op   = opcode_t'(ir[IW-1 -: 4]);
  assign fa   = ir[3*RA_W-1 -: RA_W];
  assign fb   = ir[2*RA_W-1 -: RA_W];
  assign fc   = ir[RA_W-1:0];
  assign imm  = ir[IMM_W-1:0];
  assign cond = cond_t'(ir[3*RA_W-1 -: 2]);

  mcore_seq #(.IW(IW), .PC_W(PC_W)) u_seq (
    .clk(clk), .rst(rst), .pm_data(pm_data), .op(op), .cond(cond),
    .target(imm), .f_next(alu_flags), .f_we(phase == PH_EXEC && alu_fwe),
    .phase(phase), .ir(ir), .pc(pc), .flags(flags)
  );

  mcore_regfile #(.DATA_W(DATA_W), .RA_W(RA_W)) u_rf (
    .clk(clk), .rst(rst), .we(wr_en), .widx(wr_idx), .wdata(wr_data),
    .ra(fa), .rb(fb), .rd_a(rd_a), .rd_b(rd_b)
  );

  mcore_alu #(.DATA_W(DATA_W)) u_alu (
    .op(op), .a(opa), .b(opb), .f_in(flags),
    .res(alu_res), .f_out(alu_flags), .f_we(alu_fwe)
  );

  // operand latch: sources captured in decode, so execute may overwrite them
  always_ff @(posedge clk) begin
    if (rst) begin
      opa <= '0;
      opb <= '0;
    end else if (phase == PH_DECODE) begin
      opa <= rd_a;
      opb <= rd_b;
    end
  end

  always_comb begin
    wr_en   = 1'b0;
    wr_idx  = fa;
    wr_data = alu_res;
    if (phase == PH_EXEC) begin
      unique case (op)
        OP_MOV:  begin wr_en = 1'b1; wr_idx = fb; wr_data = opa; end
        OP_LDI:  begin wr_en = 1'b1; wr_data = DATA_W'(imm); end
        OP_ILDI: begin wr_en = 1'b1; wr_idx = opa[RA_W-1:0]; wr_data = DATA_W'(imm); end
        OP_INC, OP_DEC: wr_en = 1'b1;
        OP_ADD, OP_SUB, OP_AND, OP_OR, OP_SHL, OP_SHR: begin
          wr_en = 1'b1; wr_idx = fc;
        end
        default: ;
      endcase
    end else if (phase == PH_MEMWAIT) begin
      wr_en   = 1'b1;
      wr_data = ram_rdata;
    end
  end

  assign pm_addr   = pc;
  assign ram_addr  = imm;
  assign ram_wdata = opa;
  assign ram_we    = (phase == PH_EXEC) && (op == OP_ST);
  assign ram_re    = (phase == PH_EXEC) && (op == OP_LOAD);
  assign halted    = (phase == PH_HALT);

  // R6: RAM strobes are mutually exclusive
  p_strobe_excl_r6: assert property (@(posedge clk) disable iff (rst)
    !(ram_we && ram_re));
  // R11: no RAM traffic once halted
  p_quiet_halt_r11: assert property (@(posedge clk) disable iff (rst)
    halted |-> !ram_we && !ram_re);
  // R6: a store strobe lasts a single cycle
  p_store_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    ram_we |=> !ram_we);

endmodule

// File: tb/reg8_core_test.sv
module reg8_core_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  pm_addr, ram_addr, ram_wdata, ram_rdata;
  logic [15:0] pm_data;
  logic        ram_we, ram_re, halted;

  logic [15:0] prog [256];
  logic [7:0]  ram  [256];

  int total = 0;
  int bad   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  reg8_core uut (
    .clk(clk), .rst(rst), .pm_addr(pm_addr), .pm_data(pm_data),
    .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_we(ram_we),
    .ram_re(ram_re), .ram_rdata(ram_rdata), .halted(halted)
  );

  assign pm_data = prog[pm_addr];

  always @(posedge clk) begin
    if (ram_we) ram[ram_addr] <= ram_wdata;
    if (ram_re) ram_rdata <= ram[ram_addr];
  end

  // ---------------- behavioural reference ----------------
  int          m_stage;
  logic [7:0]  m_pc;
  logic [15:0] m_ir;
  logic [7:0]  m_rf  [16];
  logic [7:0]  m_ram [256];
  logic        mz, mn, mv, mu;

  function automatic string tag_of(int op);
    case (op)
      0: return "R3";
      1, 2: return "R4";
      3: return "R5";
      4: return "R6";
      5, 6: return "R7";
      7: return "R10";
      8: return "R11";
      9, 10, 11, 12: return "R8";
      13, 14: return "R9";
      default: return "R12";
    endcase
  endfunction

  task automatic model_exec();
    int op, a, b, c, x, y, r, sr;
    logic [7:0] imm;
    op = int'(m_ir[15:12]); a = int'(m_ir[11:8]); b = int'(m_ir[7:4]); c = int'(m_ir[3:0]);
    imm = m_ir[7:0];
    x = int'(m_rf[a]); y = int'(m_rf[b]);
    m_stage = 0;
    m_pc = m_pc + 8'd1;
    r = -1;
    case (op)
      0: m_rf[b] = 8'(x);
      1: m_rf[a] = imm;
      2: m_rf[x % 16] = imm;
      3: begin m_rf[a] = m_ram[imm]; m_stage = 3; end
      4: m_ram[imm] = 8'(x);
      5: begin r = (x + 1) % 256; mv = (x == 127); m_rf[a] = 8'(r); end
      6: begin r = (x + 255) % 256; mv = (x == 128); m_rf[a] = 8'(r); end
      7: begin
        case (m_ir[11:10])
          2'd0: if (!mz) m_pc = imm;
          2'd1: if (!mn) m_pc = imm;
          2'd2: if (!mv) m_pc = imm;
          default: if (!mu) m_pc = imm;
        endcase
      end
      8: begin m_stage = 4; m_pc = m_pc - 8'd1; end
      9, 10: begin
        sr = (op == 9) ? (int'($signed(8'(x))) + int'($signed(8'(y))))
                       : (int'($signed(8'(x))) - int'($signed(8'(y))));
        mv = (sr > 127) || (sr < -128);
        r = (op == 9) ? (x + y) % 256 : (x - y + 256) % 256;
      end
      11: r = x & y;
      12: r = x | y;
      13: begin r = (y >= 8) ? 0 : (x << y) % 256; mu = 1'b0; end
      14: begin
        r  = (y >= 8) ? 0 : (x >> y);
        mu = (y >= 8) ? (x != 0) : ((x % (1 << y)) != 0);
      end
      default: ;
    endcase
    if (op >= 9 && op <= 14) m_rf[c] = 8'(r);
    if (r >= 0) begin mz = (r == 0); mn = (r >= 128); end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_stage = 0; m_pc = 8'd0; m_ir = 16'd0;
      for (int i = 0; i < 16; i++) m_rf[i] = 8'd0;
      mz = 0; mn = 0; mv = 0; mu = 0;
    end else begin
      case (m_stage)
        0: begin m_ir = prog[m_pc]; m_stage = 1; end
        1: m_stage = 2;
        2: model_exec();
        3: m_stage = 0;
        default: ;
      endcase
    end
  end

  task automatic chk(bit ok, string req, string what, logic [39:0] act, logic [39:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  // per-clock comparison, sampled on the falling edge
  always @(negedge clk) begin
    if (!rst) begin
      logic [39:0] e, a;
      logic ewe, ere;
      int op;
      string req;
      op  = int'(m_ir[15:12]);
      ewe = (m_stage == 2) && (op == 4);
      ere = (m_stage == 2) && (op == 3);
      e = {13'd0, m_pc, (m_stage == 4), ewe, ere,
           (ewe || ere) ? m_ir[7:0] : 8'd0, ewe ? m_rf[m_ir[11:8]] : 8'd0};
      a = {13'd0, pm_addr, halted, ram_we, ram_re,
           (ram_we || ram_re) ? ram_addr : 8'd0, ram_we ? ram_wdata : 8'd0};
      if (m_stage == 4) req = "R11";
      else if (m_stage < 2) req = "R2";
      else req = tag_of(op);
      chk(a === e, req, "pc/halt/strobes", a, e);
    end
  end

  // ---------------- program ----------------
  function automatic logic [15:0] i3(int op, int a, int b, int c);
    return {4'(op), 4'(a), 4'(b), 4'(c)};
  endfunction
  function automatic logic [15:0] im(int op, int a, int v);
    return {4'(op), 4'(a), 8'(v)};
  endfunction
  function automatic logic [15:0] br(int cc, int t);
    return {4'd7, 2'(cc), 2'b00, 8'(t)};
  endfunction

  task automatic run_to_halt();
    bit done = 0;
    for (int k = 0; k < 3000 && !done; k++) begin
      @(negedge clk);
      if (halted) done = 1;
    end
    if (!done) chk(1'b0, "R11", "watchdog: no halt", 40'd0, 40'd1);
    repeat (8) @(negedge clk);
    chk(halted === 1'b1, "R11", "halted held", {39'd0, halted}, 40'd1);
  endtask

  task automatic check_ram();
    for (int ad = 8'h10; ad <= 8'h1B; ad++) begin
      string req;
      req = (ad == 8'h14 || ad == 8'h19) ? "R10" : "R6";
      chk(ram[ad] === m_ram[ad], req, $sformatf("ram[%0h]", ad),
          {32'd0, ram[ad]}, {32'd0, m_ram[ad]});
    end
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      prog[i] = 16'hF000;
      ram[i] = 8'd0; m_ram[i] = 8'd0;
    end
    ram[8'h20] = 8'hA5; m_ram[8'h20] = 8'hA5;
    prog[0]  = im(1, 1, 8'h7F);
    prog[1]  = im(1, 2, 8'h01);
    prog[2]  = i3(9, 1, 2, 3);          // R8 signed overflow
    prog[3]  = im(4, 3, 8'h10);
    prog[4]  = br(2, 6);                // R10 not taken (V set)
    prog[5]  = im(4, 1, 8'h11);
    prog[6]  = i3(10, 3, 2, 4);
    prog[7]  = im(5, 4, 0);             // R7 0x7F+1
    prog[8]  = im(6, 4, 0);             // R7 0x80-1
    prog[9]  = i3(0, 4, 5, 0);          // R3
    prog[10] = im(4, 5, 8'h12);
    prog[11] = im(1, 6, 8'hF3);
    prog[12] = im(1, 7, 8'h02);
    prog[13] = i3(14, 6, 7, 8);         // R9 underflow set
    prog[14] = br(3, 17);
    prog[15] = im(4, 8, 8'h13);
    prog[16] = i3(13, 6, 7, 9);         // R9 left clears underflow
    prog[17] = br(3, 19);               // R10 taken
    prog[18] = im(4, 9, 8'h14);
    prog[19] = im(4, 9, 8'h15);
    prog[20] = im(3, 10, 8'h10);        // R5
    prog[21] = i3(11, 10, 6, 11);
    prog[22] = i3(12, 11, 2, 12);
    prog[23] = i3(9, 12, 12, 12);       // R8 dest equals sources
    prog[24] = im(4, 12, 8'h16);
    prog[25] = im(1, 13, 14);
    prog[26] = im(2, 13, 8'h5A);        // R4 indirect
    prog[27] = im(4, 14, 8'h17);
    prog[28] = im(1, 15, 3);
    prog[29] = im(6, 15, 0);
    prog[30] = br(0, 29);               // R10 loop on not-zero
    prog[31] = im(4, 15, 8'h18);
    prog[32] = 16'hF000;                // R12
    prog[33] = im(1, 0, 1);
    prog[34] = im(6, 0, 0);
    prog[35] = br(0, 40);
    prog[36] = br(1, 38);
    prog[37] = im(4, 0, 8'h19);
    prog[38] = im(1, 1, 9);
    prog[39] = i3(14, 6, 1, 2);         // R9 amount >= 8
    prog[40] = im(4, 2, 8'h1A);
    prog[41] = br(3, 45);
    prog[42] = im(3, 3, 8'h20);
    prog[43] = im(4, 3, 8'h1B);         // store right after load
    prog[44] = 16'hF000;
    prog[45] = im(8, 0, 0);             // R11

    repeat (2) @(negedge clk);
    chk(pm_addr === 8'd0 && halted === 1'b0, "R1", "reset state",
        {31'd0, pm_addr, halted}, 40'd0);
    rst = 1'b0;
    run_to_halt();
    check_ram();

    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk(pm_addr === 8'd0 && halted === 1'b0, "R1", "reset after halt",
        {31'd0, pm_addr, halted}, 40'd0);
    rst = 1'b0;
    run_to_halt();
    check_ram();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule